// File: doc/BRIEF.md
# Aperture Page Translation Cache

This block turns graphics aperture page numbers into physical page numbers. A requester offers a page number with a valid/ready handshake. A small fully associative cache answers in the next cycle when it already holds the page. On a miss, the block reads the page's table entry from main memory through a single-outstanding request/response port. It returns that entry's translation and, when caching is enabled, keeps a copy in place of the least recently used slot.

Caching is governed by one bit in a 32-bit control word, and that bit is off after reset. While the bit is off, every lookup goes to memory and nothing is kept. Any write that flips the bit empties the cache and emits a one-cycle flush request toward the graphics write buffer. The bit may flip while a table read is outstanding. In that case the returning entry is still passed to the requester, but it is never stored.

Top module: `aper_xlate_cache`

## Requirements
- R1: After reset the enable bit is 0, `cfg_rdata` is 0, `wb_flush`, `rsp_valid` and `mem_req_valid` are 0, and `req_ready` is 1.
- R2: Control word bit 7 is the read/write enable. All other bits of `cfg_rdata` read as 0, whatever was written to them.
- R3: A write that changes bit 7 (0 to 1 or 1 to 0) raises `wb_flush` for exactly the one cycle after the write edge. A write that leaves bit 7 unchanged raises no flush.
- R4: While disabled, every lookup issues a memory read, even for a page just fetched, and no fetched entry is kept.
- R5: While enabled, a lookup of a cached page gives `rsp_valid` in the cycle after acceptance, with no memory read. `rsp_ppn` is entry bits 31:12 and `rsp_ok` is entry bit 0.
- R6: On a miss, `req_ready` stays 0 from the cycle after acceptance until the cycle after the memory response. The response appears one cycle after `mem_rsp_valid`, using the same entry fields as R5.
- R7: An entry whose bit 0 is 0 is still cached when enabled. A later lookup of that page hits and returns `rsp_ok` = 0 without a memory read.
- R8: The cache holds 8 pages. A fill replaces the least recently used page, and both hits and fills count as use.
- R9: After a change of the enable bit, in either direction, no page is cached.
- R10: When the enable bit changes while a table read is outstanding, the entry is returned but not cached. This holds even if the bit has been set again by the time the response arrives.
- R11: The memory read address is `tbl_base` + 4 × page. `mem_req_valid` stays high with a stable address until `mem_req_ready`, and only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read value |
| wb_flush | output | 1 | One-cycle write-buffer flush request |
| tbl_base | input | 32 | Translation table base address |
| req_valid | input | 1 | Lookup request valid |
| req_page | input | 20 | Aperture page number to translate |
| req_ready | output | 1 | Block can accept a lookup |
| rsp_valid | output | 1 | Translation result valid (one cycle) |
| rsp_ppn | output | 20 | Physical page number |
| rsp_ok | output | 1 | Table entry valid flag |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Table entry address |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | 32 | Table entry word |

## Verification
The hardest situation to reach from the ports is an enable change that lands between a miss's memory request and its response. The worst case is an off-then-on pair, which leaves the enable bit at its old value when the data returns. The bench gets there by acting as the memory itself. It accepts the read, then holds back the response while it issues one or two control writes. It then releases the response and looks up the same page again, expecting a fresh memory read rather than a hit. Eviction order is reached by filling all eight slots and refreshing one page with a hit before forcing a ninth fill.

// File: rtl/aptc_pkg.sv
package aptc_pkg;
   typedef enum logic [1:0] {
      WK_IDLE  = 2'd0,
      WK_FETCH = 2'd1,
      WK_WAIT  = 2'd2
   } walk_state_t;
endpackage

// File: rtl/aptc_ctrl_reg.sv
module aptc_ctrl_reg #(
   parameter int REG_W  = 32,
   parameter int EN_POS = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   output logic             en,
   output logic             toggle,
   output logic             wb_flush
);
   generate
      if (EN_POS >= REG_W || EN_POS < 0) begin : g_bad_pos
         $error("aptc_ctrl_reg: EN_POS outside the control word");
      end
   endgenerate

   logic unused_wdata;
   assign unused_wdata = ^cfg_wdata;

   // a write that flips the enable
   assign toggle = cfg_wr && (cfg_wdata[EN_POS] != en);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en       <= 1'b0;
         wb_flush <= 1'b0;
      end else begin
         wb_flush <= toggle;
         if (cfg_wr) en <= cfg_wdata[EN_POS];
      end
   end

   always_comb begin
      cfg_rdata         = '0;
      cfg_rdata[EN_POS] = en;
   end

   p_flush_marks_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wb_flush |-> (en != $past(en)));
   p_quiet_without_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> (!wb_flush && $stable(en)));
endmodule

// File: rtl/aptc_tag_array.sv
module aptc_tag_array #(
   parameter int ENTRIES = 8,
   parameter int TAG_W   = 20,
   parameter int PPN_W   = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             flush,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic             lk_go,
   output logic             hit,
   output logic [PPN_W-1:0] hit_ppn,
   output logic             hit_ok,
   input  logic             fill_go,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             fill_ok
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

   generate
      if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_depth
         $error("aptc_tag_array: ENTRIES must be a power of two, at least 2");
      end
   endgenerate

   logic [TAG_W-1:0] tag_q   [ENTRIES];
   logic [PPN_W-1:0] ppn_q   [ENTRIES];
   logic [IDX_W-1:0] age_q   [ENTRIES];
   logic [ENTRIES-1:0] ok_q;
   logic [ENTRIES-1:0] valid_q;
   logic [ENTRIES-1:0] match;
   logic [ENTRIES-1:0] oldest;

   // parallel tag compare, one comparator per slot
   genvar g;
   generate
      for (g = 0; g < ENTRIES; g++) begin : g_cmp
         assign match[g]  = valid_q[g] && (tag_q[g] == lk_tag);
         assign oldest[g] = (age_q[g] == OLDEST);
      end
   endgenerate

   logic [IDX_W-1:0] hit_idx;
   logic [IDX_W-1:0] victim;
   always_comb begin
      hit_idx = '0;
      victim  = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i])  hit_idx = IDX_W'(i);
         if (oldest[i]) victim  = IDX_W'(i);
      end
   end

   assign hit     = en && (|match);
   assign hit_ppn = ppn_q[hit_idx];
   assign hit_ok  = ok_q[hit_idx];

   logic             touch_go;
   logic [IDX_W-1:0] touch_idx;
   logic [IDX_W-1:0] ref_age;
   assign touch_go  = (lk_go && hit) || fill_go;
   assign touch_idx = fill_go ? victim : hit_idx;
   assign ref_age   = age_q[touch_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         ok_q    <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            tag_q[i] <= '0;
            ppn_q[i] <= '0;
            age_q[i] <= IDX_W'(i);
         end
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (!en || flush) begin
               valid_q[i] <= 1'b0;
            end else if (fill_go && victim == IDX_W'(i)) begin
               valid_q[i] <= 1'b1;
            end
            if (fill_go && victim == IDX_W'(i)) begin
               tag_q[i] <= fill_tag;
               ppn_q[i] <= fill_ppn;
               ok_q[i]  <= fill_ok;
            end
            if (touch_go) begin
               if (touch_idx == IDX_W'(i)) begin
                  age_q[i] <= '0;
               end else if (age_q[i] < ref_age) begin
                  age_q[i] <= age_q[i] + 1'b1;
               end
            end
         end
      end
   end

   p_clear_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (valid_q == '0));
   p_toggle_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_q == '0));
   p_fill_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_go |-> (en && !flush));
   p_unique_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
   p_single_oldest_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest) == 1);
endmodule

// File: rtl/aptc_walker.sv
module aptc_walker
   import aptc_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int TAG_W   = 20,
   parameter int PPN_W   = 20,
   parameter int PPN_LSB = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              toggle,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic              req_valid,
   input  logic [TAG_W-1:0]  req_page,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [PPN_W-1:0]  rsp_ppn,
   output logic              rsp_ok,
   output logic              lk_go,
   input  logic              lk_hit,
   input  logic [PPN_W-1:0]  lk_ppn,
   input  logic              lk_ok,
   output logic              fill_go,
   output logic [TAG_W-1:0]  fill_tag,
   output logic [PPN_W-1:0]  fill_ppn,
   output logic              fill_ok,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data
);
   generate
      if (PPN_LSB < 1 || PPN_LSB + PPN_W > DATA_W) begin : g_bad_field
         $error("aptc_walker: physical page field does not fit the entry word");
      end
      if (TAG_W + 2 > ADDR_W) begin : g_bad_addr
         $error("aptc_walker: page index too wide for the address");
      end
   endgenerate

   walk_state_t      state_q;
   logic [TAG_W-1:0] cur_page_q;
   logic             stale_q;
   logic             unused_data;
   assign unused_data = ^mem_rsp_data;

   assign req_ready     = (state_q == WK_IDLE);
   assign lk_go         = req_valid && req_ready;
   assign mem_req_valid = (state_q == WK_FETCH);
   assign mem_req_addr  = tbl_base + ADDR_W'({cur_page_q, 2'b00});

   assign fill_tag = cur_page_q;
   assign fill_ppn = mem_rsp_data[PPN_LSB +: PPN_W];
   assign fill_ok  = mem_rsp_data[0];
   // any enable change since acceptance voids the fill
   assign fill_go  = (state_q == WK_WAIT) && mem_rsp_valid && en && !toggle && !stale_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= WK_IDLE;
         cur_page_q <= '0;
         stale_q    <= 1'b0;
         rsp_valid  <= 1'b0;
         rsp_ppn    <= '0;
         rsp_ok     <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         if (toggle)     stale_q <= 1'b1;
         else if (lk_go) stale_q <= 1'b0;
         case (state_q)
            WK_IDLE: begin
               if (lk_go) begin
                  if (lk_hit) begin
                     rsp_valid <= 1'b1;
                     rsp_ppn   <= lk_ppn;
                     rsp_ok    <= lk_ok;
                  end else begin
                     cur_page_q <= req_page;
                     state_q    <= WK_FETCH;
                  end
               end
            end
            WK_FETCH: begin
               if (mem_req_ready) state_q <= WK_WAIT;
            end
            WK_WAIT: begin
               if (mem_rsp_valid) begin
                  rsp_valid <= 1'b1;
                  rsp_ppn   <= fill_ppn;
                  rsp_ok    <= fill_ok;
                  state_q   <= WK_IDLE;
               end
            end
            default: state_q <= WK_IDLE;
         endcase
      end
   end

   p_hold_request_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
   p_hit_answers_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_go && lk_hit) |=> (rsp_valid && !mem_req_valid));
   p_miss_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_go && !lk_hit) |=> (!req_ready && !rsp_valid));
   p_disabled_never_hits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !lk_hit);
endmodule

// File: rtl/aper_xlate_cache.sv
module aper_xlate_cache #(
   parameter int ENTRIES = 8,
   parameter int PAGE_W  = 20,
   parameter int PPN_W   = 20,
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int CFG_W   = 32,
   parameter int EN_BIT  = 7,
   parameter int PPN_LSB = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   output logic              wb_flush,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic              req_valid,
   input  logic [PAGE_W-1:0] req_page,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [PPN_W-1:0]  rsp_ppn,
   output logic              rsp_ok,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data
);
   logic             en;
   logic             toggle;
   logic             lk_go;
   logic             lk_hit;
   logic [PPN_W-1:0] lk_ppn;
   logic             lk_ok;
   logic             fill_go;
   logic [PAGE_W-1:0] fill_tag;
   logic [PPN_W-1:0] fill_ppn;
   logic             fill_ok;

   aptc_ctrl_reg #(.REG_W(CFG_W), .EN_POS(EN_BIT)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .en(en), .toggle(toggle), .wb_flush(wb_flush)
   );

   aptc_tag_array #(.ENTRIES(ENTRIES), .TAG_W(PAGE_W), .PPN_W(PPN_W)) u_tags (
      .clk(clk), .rst_n(rst_n), .en(en), .flush(toggle),
      .lk_tag(req_page), .lk_go(lk_go),
      .hit(lk_hit), .hit_ppn(lk_ppn), .hit_ok(lk_ok),
      .fill_go(fill_go), .fill_tag(fill_tag), .fill_ppn(fill_ppn), .fill_ok(fill_ok)
   );

   aptc_walker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(PAGE_W),
                 .PPN_W(PPN_W), .PPN_LSB(PPN_LSB)) u_walk (
      .clk(clk), .rst_n(rst_n), .en(en), .toggle(toggle), .tbl_base(tbl_base),
      .req_valid(req_valid), .req_page(req_page), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_ppn(rsp_ppn), .rsp_ok(rsp_ok),
      .lk_go(lk_go), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_ok(lk_ok),
      .fill_go(fill_go), .fill_tag(fill_tag), .fill_ppn(fill_ppn), .fill_ok(fill_ok),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data)
   );

   p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);
endmodule

// File: tb/aper_xlate_cache_test.sv
`timescale 1ns/1ps
module aper_xlate_cache_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        wb_flush;
   logic [31:0] tbl_base = 32'h0040_0000;
   logic        req_valid = 1'b0;
   logic [19:0] req_page = '0;
   logic        req_ready;
   logic        rsp_valid;
   logic [19:0] rsp_ppn;
   logic        rsp_ok;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;

   always #4 clk = ~clk;

   aper_xlate_cache uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .wb_flush(wb_flush), .tbl_base(tbl_base),
      .req_valid(req_valid), .req_page(req_page), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_ppn(rsp_ppn), .rsp_ok(rsp_ok),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   // reference model state
   bit          en_m = 1'b0;
   bit          stale_m = 1'b0;
   bit          exp_flush = 1'b0;
   logic [19:0] cache_m[$];

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] entry_of(input logic [19:0] pg);
      return {pg ^ 20'h5A3C1, 11'h000, ~pg[2]};
   endfunction

   function automatic int find_m(input logic [19:0] pg);
      foreach (cache_m[i]) if (cache_m[i] == pg) return i;
      return -1;
   endfunction

   // every clock: control word and flush pulse versus the model (R2, R3)
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         chk(cfg_rdata === {24'h0, en_m, 7'h0}, "R2", cfg_rdata, {24'h0, en_m, 7'h0});
         chk(wb_flush === exp_flush, "R3", {31'h0, wb_flush}, {31'h0, exp_flush});
      end
   end

   task automatic cfg_put(input logic [31:0] d);
      cfg_wr = 1'b1;
      cfg_wdata = d;
      if (d[7] != en_m) begin
         exp_flush = 1'b1;
         stale_m = 1'b1;
         cache_m.delete();
      end
      en_m = d[7];
      @(negedge clk);
      cfg_wr = 1'b0;
      exp_flush = 1'b0;
   endtask

   // tog: 0 none, 1 disable during the wait, 2 disable then re-enable
   task automatic lookup(input logic [19:0] pg, input int rdy_wait, input int tog, input string rq);
      logic [31:0] ent;
      logic [31:0] exp_addr;
      int idx;
      ent = entry_of(pg);
      exp_addr = tbl_base + {10'h0, pg, 2'b00};
      idx = en_m ? find_m(pg) : -1;
      stale_m = 1'b0;
      chk(req_ready === 1'b1, rq, {31'h0, req_ready}, 1);
      req_valid = 1'b1;
      req_page = pg;
      @(negedge clk);
      req_valid = 1'b0;
      if (idx >= 0) begin
         chk(rsp_valid === 1'b1, rq, {31'h0, rsp_valid}, 1);
         chk(rsp_ppn === ent[31:12], rq, {12'h0, rsp_ppn}, {12'h0, ent[31:12]});
         chk(rsp_ok === ent[0], rq, {31'h0, rsp_ok}, {31'h0, ent[0]});
         chk(mem_req_valid === 1'b0, rq, {31'h0, mem_req_valid}, 0);
         cache_m.delete(idx);
         cache_m.push_front(pg);
      end else begin
         chk(rsp_valid === 1'b0, rq, {31'h0, rsp_valid}, 0);
         chk(req_ready === 1'b0, "R6", {31'h0, req_ready}, 0);
         chk(mem_req_valid === 1'b1, rq, {31'h0, mem_req_valid}, 1);
         chk(mem_req_addr === exp_addr, "R11", mem_req_addr, exp_addr);
         for (int k = 0; k < rdy_wait; k++) begin
            @(negedge clk);
            chk(mem_req_valid === 1'b1, "R11", {31'h0, mem_req_valid}, 1);
            chk(mem_req_addr === exp_addr, "R11", mem_req_addr, exp_addr);
         end
         mem_req_ready = 1'b1;
         @(negedge clk);
         mem_req_ready = 1'b0;
         chk(mem_req_valid === 1'b0, "R11", {31'h0, mem_req_valid}, 0);
         chk(req_ready === 1'b0, "R6", {31'h0, req_ready}, 0);
         if (tog == 1) begin
            cfg_put(32'h0);
         end else if (tog == 2) begin
            cfg_put(32'h0);
            cfg_put(32'h80);
         end
         mem_rsp_valid = 1'b1;
         mem_rsp_data = ent;
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         chk(rsp_valid === 1'b1, "R6", {31'h0, rsp_valid}, 1);
         chk(rsp_ppn === ent[31:12], "R6", {12'h0, rsp_ppn}, {12'h0, ent[31:12]});
         chk(rsp_ok === ent[0], "R6", {31'h0, rsp_ok}, {31'h0, ent[0]});
         chk(req_ready === 1'b1, "R6", {31'h0, req_ready}, 1);
         if (en_m && !stale_m) begin
            cache_m.push_front(pg);
            if (cache_m.size() > 8) void'(cache_m.pop_back());
         end
      end
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cfg_rdata === 32'h0, "R1", cfg_rdata, 0);
      chk(wb_flush === 1'b0, "R1", {31'h0, wb_flush}, 0);
      chk(rsp_valid === 1'b0, "R1", {31'h0, rsp_valid}, 0);
      chk(mem_req_valid === 1'b0, "R1", {31'h0, mem_req_valid}, 0);
      chk(req_ready === 1'b1, "R1", {31'h0, req_ready}, 1);

      // R2 reserved bits read zero, R3 no pulse without a change
      cfg_put(32'hFFFF_FF7F);
      @(negedge clk);

      // R4 disabled: repeated page still goes to memory
      lookup(20'h00010, 0, 0, "R4");
      lookup(20'h00010, 0, 0, "R4");

      // R3 enable produces a pulse; same value again does not
      cfg_put(32'h0000_0080);
      @(negedge clk);
      cfg_put(32'hFFFF_FFFF);
      @(negedge clk);

      // R6 fill eight slots, R5/R7 hit them all (0x104..0x107 carry bit0 = 0)
      for (int i = 0; i < 8; i++) lookup(20'h00100 + 20'(i), 0, 0, "R6");
      for (int i = 0; i < 8; i++) lookup(20'h00100 + 20'(i), 0, 0, (i >= 4) ? "R7" : "R5");

      // R8 refresh 0x100, a ninth page evicts the oldest other one
      lookup(20'h00100, 0, 0, "R8");
      lookup(20'h00200, 2, 0, "R11");
      lookup(20'h00100, 0, 0, "R8");
      lookup(20'h00101, 0, 0, "R8");
      lookup(20'h00102, 0, 0, "R8");
      lookup(20'h00107, 0, 0, "R8");

      // R9 off and on empties the cache
      cfg_put(32'h0);
      cfg_put(32'h80);
      @(negedge clk);
      lookup(20'h00107, 0, 0, "R9");
      lookup(20'h00100, 0, 0, "R9");

      // R10 off-then-on while the read is outstanding
      lookup(20'h00300, 1, 2, "R10");
      lookup(20'h00300, 0, 0, "R10");
      lookup(20'h00300, 0, 0, "R10");
      lookup(20'h00304, 0, 0, "R7");

      // R10 disabled during the read, then R4 while off
      lookup(20'h00301, 3, 1, "R10");
      lookup(20'h00301, 0, 0, "R4");
      cfg_put(32'h80);
      @(negedge clk);
      lookup(20'h00301, 0, 0, "R9");
      lookup(20'h00301, 0, 0, "R5");

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule